// File: doc/BRIEF.md
# Serial Link Training Controller

This block steers one end of a point-to-point serial tunnelling link from power-up to the operating state. After reset it transmits discovery frames until the receive path reports frame alignment and enough frames have passed in both directions. It then negotiates a common line rate and asks the clocking logic to switch to that rate. It waits for the link to realign at the new rate and finally raises an operational flag that enables channel tunnelling. A single parameter selects the controller role or the host role. The role changes only the condition that ends the speed-negotiation stage.

The surrounding logic provides four things: a frame-alignment level, a clock-lock level, a one-cycle strobe for each frame the encoder finishes sending, and the decoded type of each received frame with a valid strobe. In return the block names the frame type to send next. It also gives a one-cycle clock-change request with the chosen rate index, the operational flag, and a binary state field with a pulse on each state change.

Top module: `lnk_train`

## Requirements
- R1: During and after reset the state field is 0 (detect). The operational flag, the speed request and the state-change pulse are 0, and the transmit frame type is 1 (detect frame).
- R2: In detect, a sent frame counts only while alignment is high. The block leaves detect only once DET_TX_MIN sent frames and DET_RX_MIN received detect frames (type 1) have been counted while aligned.
- R3: A received speed frame (type 2) while in detect moves the block to the speed stage (state 1) on the next clock, whatever the counts are.
- R4: The transmit frame type is 1 in detect, 2 in the speed stage and during realignment, and 3 (operational frame) in the operating state.
- R5: In the controller role, the speed stage ends after SPD_TX_MIN frames have been sent within it.
- R6: In the host role, the speed stage ends after SPD_RX_MIN speed frames (type 2) have been received within it.
- R7: When the speed stage ends, speed_req pulses for one cycle and the block enters realignment (state 2). speed_sel takes the index of the highest bit set in both LCL_CAP and partner_cap, or 0 if no bit is common, and holds that value.
- R8: In realignment, alignment and clock lock both high move the block to the operating state (state 3) on the next clock. The operational flag is high exactly while in that state.
- R9: If realignment has not succeeded after TMO_CYC cycles in the state, the block returns to detect.
- R10: In the operating state, a loss of alignment returns the block to detect on the next clock.
- R11: state_chg pulses for exactly one cycle, in the first cycle of each new state value.
- R12: Both frame counters restart from zero on every state change, so no count carries into the next stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aligned | input | 1 | Receive frame alignment achieved |
| pll_lock | input | 1 | Reconfigured clock is locked |
| tx_done | input | 1 | One-cycle strobe per frame sent |
| rx_vld | input | 1 | Received frame type valid |
| rx_type | input | 2 | Received frame type: 1 detect, 2 speed, 3 operational |
| partner_cap | input | SPD_W | Partner rate capability mask |
| tx_type | output | 2 | Frame type to send next |
| speed_req | output | 1 | One-cycle clock-change request |
| speed_sel | output | SEL_W | Selected rate index |
| op | output | 1 | Operational, tunnelling enabled |
| state | output | 2 | 0 detect, 1 speed, 2 realign, 3 operational |
| state_chg | output | 1 | Pulse on each state change |

## Verification
The hardest case to reach is two ends that leave the speed stage at different times, with one of them then timing out in realignment while the other is still negotiating. The bench drives a controller instance and a host instance with the same stimulus. It first sends only transmit strobes, which moves the controller into realignment and leaves the host waiting. It then sends only speed frames to release the host. Clock lock stays low during all of this, so each end runs out its shortened timeout on its own schedule. A behavioural model of both roles is compared on every cycle, and directed checks cover the same path.

// File: rtl/lnk_train_pkg.sv
package lnk_train_pkg;

  typedef enum logic [1:0] {
    ST_DET  = 2'd0,
    ST_SPD  = 2'd1,
    ST_RALN = 2'd2,
    ST_OP   = 2'd3
  } lt_state_e;

  localparam logic [1:0] FT_IDLE = 2'd0;
  localparam logic [1:0] FT_DET  = 2'd1;
  localparam logic [1:0] FT_SPD  = 2'd2;
  localparam logic [1:0] FT_OPR  = 2'd3;

  function automatic logic [1:0] frame_for(lt_state_e s);
    case (s)
      ST_DET:  return FT_DET;
      ST_SPD:  return FT_SPD;
      ST_RALN: return FT_SPD;
      default: return FT_OPR;
    endcase
  endfunction

endpackage

// File: rtl/lnk_frm_cnt.sv
module lnk_frm_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != SAT) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lnk_spd_pick.sv
module lnk_spd_pick #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic [N-1:0]  loc,
  input  logic [N-1:0]  par,
  output logic [SW-1:0] sel
);
  logic [N-1:0] both;
  assign both = loc & par;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (both[i]) sel = SW'(i);
    end
  end
endmodule

// File: rtl/lnk_tmo.sv
module lnk_tmo #(
  parameter int LIM = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIM > 2) ? $clog2(LIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst || !run) cyc <= '0;
    else if (cyc != LAST) cyc <= cyc + 1'b1;
  end

  assign expired = run && (cyc == LAST);
endmodule

// File: rtl/lnk_train.sv
module lnk_train
  import lnk_train_pkg::*;
#(
  parameter bit          IS_CTRL    = 1'b1,
  parameter int          SPD_W      = 4,
  parameter logic [SPD_W-1:0] LCL_CAP = 4'b1011,
  parameter int          DET_TX_MIN = 255,
  parameter int          DET_RX_MIN = 7,
  parameter int          SPD_TX_MIN = 7,
  parameter int          SPD_RX_MIN = 3,
  parameter int          TMO_CYC    = 5_000_000,
  localparam int         SEL_W      = (SPD_W > 1) ? $clog2(SPD_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aligned,
  input  logic             pll_lock,
  input  logic             tx_done,
  input  logic             rx_vld,
  input  logic [1:0]       rx_type,
  input  logic [SPD_W-1:0] partner_cap,
  output logic [1:0]       tx_type,
  output logic             speed_req,
  output logic [SEL_W-1:0] speed_sel,
  output logic             op,
  output logic [1:0]       state,
  output logic             state_chg
);
  localparam int MAX_A  = (DET_TX_MIN > DET_RX_MIN) ? DET_TX_MIN : DET_RX_MIN;
  localparam int MAX_B  = (SPD_TX_MIN > SPD_RX_MIN) ? SPD_TX_MIN : SPD_RX_MIN;
  localparam int MAX_TH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_TH + 1);
  localparam logic [CNT_W-1:0] DET_TX_TH = CNT_W'(DET_TX_MIN);
  localparam logic [CNT_W-1:0] DET_RX_TH = CNT_W'(DET_RX_MIN);
  localparam logic [CNT_W-1:0] SPD_TX_TH = CNT_W'(SPD_TX_MIN);
  localparam logic [CNT_W-1:0] SPD_RX_TH = CNT_W'(SPD_RX_MIN);

  lt_state_e        st, nxt;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_inc, rx_inc, cnt_clr;
  logic             spd_done, tmo_exp, det_done, early;
  logic [SEL_W-1:0] pick;

  // ---- frame counters -------------------------------------------------
  assign tx_inc = tx_done && (st == ST_SPD || (st == ST_DET && aligned));
  assign rx_inc = rx_vld && ((st == ST_DET && aligned && rx_type == FT_DET) ||
                             (st == ST_SPD && rx_type == FT_SPD));
  assign cnt_clr = (nxt != st);

  lnk_frm_cnt #(.W(CNT_W)) u_txc (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(tx_inc), .cnt(tx_cnt)
  );
  lnk_frm_cnt #(.W(CNT_W)) u_rxc (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(rx_inc), .cnt(rx_cnt)
  );

  // ---- role-dependent speed-stage exit --------------------------------
  generate
    if (IS_CTRL) begin : g_ctrl
      assign spd_done = (tx_cnt >= SPD_TX_TH);
    end else begin : g_host
      assign spd_done = (rx_cnt >= SPD_RX_TH);
    end
  endgenerate

  // ---- rate choice and realignment timer ------------------------------
  lnk_spd_pick #(.N(SPD_W), .SW(SEL_W)) u_pick (
    .loc(LCL_CAP), .par(partner_cap), .sel(pick)
  );

  lnk_tmo #(.LIM(TMO_CYC)) u_tmo (
    .clk(clk), .rst(rst), .run(st == ST_RALN), .expired(tmo_exp)
  );

  // ---- state machine --------------------------------------------------
  assign early    = rx_vld && (rx_type == FT_SPD);
  assign det_done = aligned && (tx_cnt >= DET_TX_TH) && (rx_cnt >= DET_RX_TH);

  always_comb begin
    nxt = st;
    case (st)
      ST_DET:  if (early || det_done) nxt = ST_SPD;
      ST_SPD:  if (spd_done) nxt = ST_RALN;
      ST_RALN: begin
        if (aligned && pll_lock) nxt = ST_OP;
        else if (tmo_exp)        nxt = ST_DET;
      end
      default: if (!aligned) nxt = ST_DET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_DET;
      op        <= 1'b0;
      tx_type   <= FT_DET;
      state_chg <= 1'b0;
      speed_req <= 1'b0;
      speed_sel <= '0;
    end else begin
      st        <= nxt;
      op        <= (nxt == ST_OP);
      tx_type   <= frame_for(nxt);
      state_chg <= (nxt != st);
      speed_req <= (st == ST_SPD) && (nxt == ST_RALN);
      if (st == ST_SPD && nxt == ST_RALN) speed_sel <= pick;
    end
  end

  assign state = st;

  // ---- assertions -----------------------------------------------------
  a_r2_hold_det: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DET && !early && tx_cnt < DET_TX_TH) |=> (st == ST_DET));

  a_r3_early_adv: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DET && rx_vld && rx_type == FT_SPD) |=> (st == ST_SPD));

  a_r7_req_pulse: assert property (@(posedge clk) disable iff (rst)
    speed_req |=> !speed_req);

  a_r7_req_entry: assert property (@(posedge clk) disable iff (rst)
    speed_req |-> (st == ST_RALN && $past(st) == ST_SPD));

  a_r8_realign_ok: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RALN && aligned && pll_lock) |=> (st == ST_OP && op));

  a_r9_timeout: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RALN && tmo_exp && !(aligned && pll_lock)) |=> (st == ST_DET));

  a_r10_op_flag: assert property (@(posedge clk) disable iff (rst)
    op |-> (st == ST_OP));

  a_r10_loss: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OP && !aligned) |=> (st == ST_DET));

  a_r11_chg_pulse: assert property (@(posedge clk) disable iff (rst)
    (st != $past(st)) |-> state_chg);

  a_r12_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    state_chg |-> (tx_cnt == '0 && rx_cnt == '0));

endmodule

// File: tb/lnk_train_tb_top.sv
module lnk_train_tb_top;
  localparam int SPD_W = 4;
  localparam int TMO   = 40;
  localparam logic [SPD_W-1:0] LCAP = 4'b1011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aligned = 1'b0, pll_lock = 1'b0, tx_done = 1'b0, rx_vld = 1'b0;
  logic [1:0] rx_type = 2'd0;
  logic [SPD_W-1:0] partner_cap = '0;

  always #10 clk = ~clk;

  logic [1:0] o_tx [2];
  logic       o_req [2];
  logic [1:0] o_sel [2];
  logic       o_op [2];
  logic [1:0] o_st [2];
  logic       o_chg [2];

  lnk_train #(.IS_CTRL(1'b1), .SPD_W(SPD_W), .LCL_CAP(LCAP), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .aligned(aligned), .pll_lock(pll_lock), .tx_done(tx_done),
    .rx_vld(rx_vld), .rx_type(rx_type), .partner_cap(partner_cap),
    .tx_type(o_tx[0]), .speed_req(o_req[0]), .speed_sel(o_sel[0]), .op(o_op[0]),
    .state(o_st[0]), .state_chg(o_chg[0]));

  lnk_train #(.IS_CTRL(1'b0), .SPD_W(SPD_W), .LCL_CAP(LCAP), .TMO_CYC(TMO)) dut_h (
    .clk(clk), .rst(rst), .aligned(aligned), .pll_lock(pll_lock), .tx_done(tx_done),
    .rx_vld(rx_vld), .rx_type(rx_type), .partner_cap(partner_cap),
    .tx_type(o_tx[1]), .speed_req(o_req[1]), .speed_sel(o_sel[1]), .op(o_op[1]),
    .state(o_st[1]), .state_chg(o_chg[1]));

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // ---- behavioural reference model, role 0 controller, role 1 host ----
  int m_st [2], m_tx [2], m_rx [2], m_tmo [2], m_sel [2];
  bit m_req [2], m_chg [2];

  function automatic int best_rate(input logic [SPD_W-1:0] p);
    int b = 0;
    for (int i = SPD_W - 1; i >= 0; i--) begin
      if (LCAP[i] && p[i]) begin b = i; break; end
    end
    return b;
  endfunction

  always @(posedge clk) begin
    for (int r = 0; r < 2; r++) begin
      if (rst) begin
        m_st[r] = 0; m_tx[r] = 0; m_rx[r] = 0; m_tmo[r] = 0;
        m_sel[r] = 0; m_req[r] = 0; m_chg[r] = 0;
      end else begin
        int s, nx;
        s = m_st[r];
        nx = s;
        case (s)
          0: if (rx_vld && rx_type == 2) nx = 1;
             else if (aligned && m_tx[r] >= 255 && m_rx[r] >= 7) nx = 1;
          1: if ((r == 0) ? (m_tx[r] >= 7) : (m_rx[r] >= 3)) nx = 2;
          2: if (aligned && pll_lock) nx = 3;
             else if (m_tmo[r] == TMO - 1) nx = 0;
          default: if (!aligned) nx = 0;
        endcase
        if (nx != s) begin
          m_tx[r] = 0; m_rx[r] = 0;
        end else begin
          if (tx_done && (s == 1 || (s == 0 && aligned))) m_tx[r]++;
          if (rx_vld && ((s == 0 && aligned && rx_type == 1) || (s == 1 && rx_type == 2)))
            m_rx[r]++;
        end
        m_tmo[r] = (s == 2 && nx == 2) ? m_tmo[r] + 1 : 0;
        m_req[r] = (s == 1 && nx == 2);
        if (m_req[r]) m_sel[r] = best_rate(partner_cap);
        m_chg[r] = (nx != s);
        m_st[r] = nx;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int r = 0; r < 2; r++) begin
        check("R11 state", o_st[r], m_st[r]);
        check("R11 state_chg", o_chg[r], m_chg[r]);
        check("R4 tx_type", o_tx[r], (m_st[r] == 0) ? 1 : (m_st[r] == 3) ? 3 : 2);
        check("R8 op", o_op[r], m_st[r] == 3);
        check("R7 speed_req", o_req[r], m_req[r]);
        check("R7 speed_sel", o_sel[r], m_sel[r]);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input int r, input int s, input int lim, input string tag);
    int n = 0;
    while (o_st[r] != s && n < lim) begin
      @(negedge clk);
      n++;
    end
    check(tag, o_st[r], s);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(4);
    for (int r = 0; r < 2; r++) begin
      check("R1 reset state", o_st[r], 0);
      check("R1 reset op", o_op[r], 0);
      check("R1 reset tx_type", o_tx[r], 1);
      check("R1 reset req", o_req[r], 0);
      check("R1 reset chg", o_chg[r], 0);
    end
    rst = 1'b0;

    // R2: frames while unaligned do not count
    tx_done = 1'b1; rx_vld = 1'b1; rx_type = 2'd1;
    cyc(300);
    check("R2 unaligned stays detect ctrl", o_st[0], 0);
    check("R2 unaligned stays detect host", o_st[1], 0);
    aligned = 1'b1;
    cyc(255);
    check("R2 threshold not yet met", o_st[0], 0);
    cyc(1);
    check("R2 threshold met ctrl", o_st[0], 1);
    check("R2 threshold met host", o_st[1], 1);

    // full climb to operation, partner 0110 -> index 1
    partner_cap = 4'b0110; pll_lock = 1'b1; rx_type = 2'd2;
    wait_st(0, 3, 50, "R8 ctrl reaches op");
    wait_st(1, 3, 50, "R8 host reaches op");
    check("R7 sel common ctrl", o_sel[0], 1);
    check("R7 sel common host", o_sel[1], 1);
    check("R10 op flag", o_op[0], 1);

    // R10: alignment loss
    aligned = 1'b0;
    cyc(1);
    check("R10 loss returns detect ctrl", o_st[0], 0);
    check("R10 loss returns detect host", o_st[1], 0);

    // R3: early advance on a received speed frame
    aligned = 1'b1; pll_lock = 1'b0; rx_type = 2'd1; partner_cap = 4'b1111;
    cyc(10);
    rx_type = 2'd2;
    cyc(1);
    check("R3 early advance ctrl", o_st[0], 1);
    check("R3 early advance host", o_st[1], 1);
    tx_done = 1'b0; rx_vld = 1'b0;
    cyc(20);
    check("R5 ctrl waits in speed", o_st[0], 1);
    check("R6 host waits in speed", o_st[1], 1);

    // R5: controller leaves on sent frames only
    tx_done = 1'b1;
    cyc(7);
    tx_done = 1'b0;
    cyc(2);
    check("R5 ctrl left speed", o_st[0], 2);
    check("R6 host still speed", o_st[1], 1);
    check("R7 sel highest common", o_sel[0], 3);

    // R6: host leaves on received speed frames
    rx_vld = 1'b1; rx_type = 2'd2;
    cyc(3);
    rx_vld = 1'b0;
    cyc(2);
    check("R6 host left speed", o_st[1], 2);

    // R9: both time out without clock lock
    wait_st(0, 0, TMO + 10, "R9 ctrl timeout");
    wait_st(1, 0, TMO + 10, "R9 host timeout");

    // R12: counts restart after returning to detect
    tx_done = 1'b1; rx_vld = 1'b1; rx_type = 2'd1;
    cyc(200);
    check("R12 counts restarted ctrl", o_st[0], 0);
    check("R12 counts restarted host", o_st[1], 0);

    // no common rate -> index 0
    partner_cap = 4'b0100;
    wait_st(0, 1, 100, "R2 second detect exit");
    rx_type = 2'd2; pll_lock = 1'b1;
    wait_st(0, 3, 50, "R8 ctrl op again");
    wait_st(1, 3, 50, "R8 host op again");
    check("R7 no common ctrl", o_sel[0], 0);
    check("R7 no common host", o_sel[1], 0);
    check("R4 op frame type", o_tx[0], 3);
    cyc(3);
    finish_run();
  end
endmodule